// File: doc/BRIEF.md
# Slow Timekeeping Clock Source Selector

This block produces the enable tick that paces a slow timekeeping domain. It chooses between two oscillator inputs, an external 32 kHz crystal and an internal RC oscillator, both sampled in the system clock domain. Before either input is used, it is synchronised and reduced to one event per rising edge. The crystal path passes edges through one for one. The RC path first goes through a fixed pre-divider chosen at build time, and then through a divide-by-(P+1) stage that software programs.

Software controls the block through a small register bus. The source-select register is protected: a write takes effect only when its upper half carries a key word. The divide value sits in its own register. A third register enables a pin output that toggles on every tick, so it carries a square wave at half the tick rate. Whenever the divide value or the source changes, the divider count restarts, so the first period after a change is never longer than the new period.

Top module: `slowclk_sel`

## Requirements
- R1: After reset the internal RC source is selected, P is 0, the output gate is off, all three registers read 0, and `tick_o` and `clkout_o` are low.
- R2: A write to offset 0x00 whose bits [31:16] equal 0x16AA loads bit 0 into the source select (1 = external crystal, 0 = internal RC). A read of 0x00 returns the source in bit 0, with every other bit, including [31:16], reading zero.
- R3: A write to offset 0x00 whose bits [31:16] differ from 0x16AA is ignored. The source does not change, and tick generation continues unchanged.
- R4: With the crystal selected, `tick_o` pulses once for each rising edge of `xtal_in`, and edges on `rc_osc_in` produce no ticks.
- R5: With the RC source selected, `tick_o` pulses once for every D×(P+1) rising edges of `rc_osc_in`. D is the `PREDIV` parameter, or 1 when `PREDIV` is 0 or 1. Edges on `xtal_in` produce no ticks.
- R6: A write to offset 0x08 loads P from bits [4:0]. No key is needed and the upper bits are discarded. A read returns P zero-extended. P = 31 divides by 32.
- R7: A write that changes P or the source clears both divider counters, so the first tick after it comes exactly D×(P+1) RC edges later.
- R8: Bit 0 of offset 0x60 enables the clock output. While it is 0, `clkout_o` is low, starting one cycle after the gate turns off. While it is 1, `clkout_o` toggles one cycle after each tick.
- R9: `tick_o` is high for exactly one system clock cycle per tick.
- R10: Reads from any offset other than 0x00, 0x08 and 0x60 return 0, and writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rc_osc_in | input | 1 | Internal RC oscillator, asynchronous |
| xtal_in | input | 1 | External crystal oscillator, asynchronous |
| tick_o | output | 1 | One-cycle slow-clock enable |
| clkout_o | output | 1 | Gated slow clock for the output pin |

## Verification
The assertions assume that each oscillator input stays high and low for at least two system clock cycles. Under that assumption, edge events can never fall on consecutive cycles, which is what the single-cycle tick and the one-event-to-one-tick relation depend on. The bench holds each oscillator level for four cycles. It changes registers only while both oscillators are idle, so a configuration write never lands in the same cycle as an edge event. Two instances share the stimulus: one with a pre-divider of 4 and one bypassed. This lets each tick count be predicted from edge counts alone.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PW     = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PRESC = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_GATE  = 8'h60;
  localparam logic [15:0]       CTRL_KEY  = 16'h16AA;

  // Key check on a control write
  function automatic logic key_ok(logic [DATA_W-1:0] w);
    return w[DATA_W-1:DATA_W-16] == CTRL_KEY;
  endfunction

  // Divider wraps when the count has reached the programmed value
  function automatic logic div_wrap(logic [PW-1:0] cnt, logic [PW-1:0] p);
    return cnt >= p;
  endfunction

  // Effective fixed pre-divide ratio (0 and 1 both mean bypass)
  function automatic int unsigned eff_prediv(int unsigned d);
    return (d < 2) ? 1 : d;
  endfunction
endpackage

// File: rtl/slowclk_edge.sv
module slowclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic rise_evt
);
  logic s0, s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b0;
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s0 <= raw_in;
      s1 <= s0;
      s2 <= s1;
    end
  end

  assign rise_evt = s1 & ~s2;
endmodule

// File: rtl/slowclk_regs.sv
module slowclk_regs
  import slowclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              src_sel,
  output logic [PW-1:0]     presc,
  output logic              gate_en,
  output logic              restart
);
  logic wr_ctrl, wr_presc, wr_gate;

  assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL) && key_ok(bus_wdata);
  assign wr_presc = bus_we && (bus_addr == OFS_PRESC);
  assign wr_gate  = bus_we && (bus_addr == OFS_GATE);

  assign restart = (wr_ctrl && (bus_wdata[0] != src_sel)) ||
                   (wr_presc && (bus_wdata[PW-1:0] != presc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= 1'b0;
      presc   <= '0;
      gate_en <= 1'b0;
    end else begin
      if (wr_ctrl)  src_sel <= bus_wdata[0];
      if (wr_presc) presc   <= bus_wdata[PW-1:0];
      if (wr_gate)  gate_en <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL:  bus_rdata[0]    = src_sel;
      OFS_PRESC: bus_rdata[PW-1:0] = presc;
      OFS_GATE:  bus_rdata[0]    = gate_en;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/slowclk_div.sv
module slowclk_div
  import slowclk_pkg::*;
#(
  parameter int unsigned PREDIV = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          src_sel,
  input  logic [PW-1:0] presc,
  input  logic          rc_evt,
  input  logic          xtal_evt,
  output logic          tick_o,
  output logic [PW-1:0] div_cnt
);
  localparam int unsigned DEFF = eff_prediv(PREDIV);

  logic pre_evt;
  logic int_hit;

  generate
    if (DEFF > 1) begin : g_pre
      localparam int CW = $clog2(DEFF);
      localparam logic [CW-1:0] LAST = CW'(DEFF - 1);
      logic [CW-1:0] pcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pcnt <= '0;
        else if (restart) pcnt <= '0;
        else if (rc_evt)  pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
      end
      assign pre_evt = rc_evt && (pcnt == LAST);
    end else begin : g_byp
      assign pre_evt = rc_evt;
    end
  endgenerate

  assign int_hit = pre_evt && div_wrap(div_cnt, presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      tick_o  <= 1'b0;
    end else begin
      if (restart)      div_cnt <= '0;
      else if (int_hit) div_cnt <= '0;
      else if (pre_evt) div_cnt <= div_cnt + 1'b1;
      tick_o <= !restart && (src_sel ? xtal_evt : int_hit);
    end
  end
endmodule

// File: rtl/slowclk_sel.sv
module slowclk_sel
  import slowclk_pkg::*;
#(
  parameter int unsigned PREDIV = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rc_osc_in,
  input  logic              xtal_in,
  output logic              tick_o,
  output logic              clkout_o
);
  // Named internal events for the checker
  logic          src_sel;
  logic [PW-1:0] presc;
  logic          gate_en;
  logic          restart;
  logic          rc_evt;
  logic          xtal_evt;
  logic [PW-1:0] div_cnt;
  logic [1:0]    osc_raw;
  logic [1:0]    osc_evt;

  assign osc_raw  = {xtal_in, rc_osc_in};
  assign rc_evt   = osc_evt[0];
  assign xtal_evt = osc_evt[1];

  generate
    for (genvar i = 0; i < 2; i++) begin : g_sync
      slowclk_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (osc_raw[i]),
        .rise_evt (osc_evt[i])
      );
    end
  endgenerate

  slowclk_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .src_sel   (src_sel),
    .presc     (presc),
    .gate_en   (gate_en),
    .restart   (restart)
  );

  slowclk_div #(.PREDIV(PREDIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .src_sel  (src_sel),
    .presc    (presc),
    .rc_evt   (rc_evt),
    .xtal_evt (xtal_evt),
    .tick_o   (tick_o),
    .div_cnt  (div_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       clkout_o <= 1'b0;
    else if (!gate_en) clkout_o <= 1'b0;
    else if (tick_o)  clkout_o <= ~clkout_o;
  end
endmodule

// File: rtl/slowclk_sel_chk.sv
module slowclk_sel_chk
  import slowclk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              src_sel,
  input logic [PW-1:0]     presc,
  input logic              gate_en,
  input logic              restart,
  input logic              xtal_evt,
  input logic [PW-1:0]     div_cnt,
  input logic              tick_o,
  input logic              clkout_o
);
  p_key_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_CTRL && bus_wdata[31:16] == 16'h16AA)
      |=> src_sel == $past(bus_wdata[0]));

  p_nokey_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_CTRL && bus_wdata[31:16] != 16'h16AA)
      |=> $stable(src_sel));

  p_ext_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && xtal_evt && !restart) |=> tick_o);

  p_ext_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && !xtal_evt) |=> !tick_o);

  p_presc_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_PRESC) |=> presc == $past(bus_wdata[4:0]));

  p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (div_cnt == '0 && !tick_o));

  p_gate_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> !clkout_o);

  p_gate_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && tick_o) |=> clkout_o != $past(clkout_o));

  p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

bind slowclk_sel slowclk_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .src_sel   (src_sel),
  .presc     (presc),
  .gate_en   (gate_en),
  .restart   (restart),
  .xtal_evt  (xtal_evt),
  .div_cnt   (div_cnt),
  .tick_o    (tick_o),
  .clkout_o  (clkout_o)
);

// File: tb/slowclk_sel_tb.sv
module slowclk_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] rdata_a, rdata_b;
  logic        rc = 1'b0, xt = 1'b0;
  logic        tick_a, tick_b, clko_a, clko_b;

  int checks = 0, errors = 0;
  int ticks_a = 0, ticks_b = 0, run_a = 0, max_run = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Pre-divider 4
  slowclk_sel #(.PREDIV(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(rdata_a), .rc_osc_in(rc), .xtal_in(xt),
    .tick_o(tick_a), .clkout_o(clko_a));

  // Pre-divider bypassed
  slowclk_sel #(.PREDIV(0)) u_dut_byp (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(rdata_b), .rc_osc_in(rc), .xtal_in(xt),
    .tick_o(tick_b), .clkout_o(clko_b));

  always @(negedge clk) begin
    if (rst_n) begin
      if (tick_a) begin ticks_a++; run_a++; end else run_a = 0;
      if (run_a > max_run) max_run = run_a;
      if (tick_b) ticks_b++;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = rdata_a;
  endtask

  task automatic pulse_rc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rc = 1'b1; repeat (4) @(negedge clk); rc = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_xt(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xt = 1'b1; repeat (4) @(negedge clk); xt = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); check("R1 ctrl after reset", d, 0);
    rd(8'h08, d); check("R1 presc after reset", d, 0);
    rd(8'h60, d); check("R1 gate after reset", d, 0);
    check("R1 tick low", tick_a, 0);
    check("R1 clkout low", clko_a, 0);
  endtask

  task automatic t_nokey_internal();
    logic [31:0] d;
    int a0;
    wr(8'h00, 32'h0000_0001);
    rd(8'h00, d); check("R3 unkeyed write ignored", d, 0);
    a0 = ticks_a;
    pulse_xt(4);
    check("R5 xtal ignored while internal", ticks_a - a0, 0);
  endtask

  task automatic t_external();
    logic [31:0] d;
    int a0, b0;
    wr(8'h00, 32'h16AA_0001);
    rd(8'h00, d); check("R2 keyed select external, key reads zero", d, 1);
    a0 = ticks_a; b0 = ticks_b;
    pulse_xt(3);
    check("R4 one tick per xtal edge", ticks_a - a0, 3);
    check("R4 one tick per xtal edge bypass inst", ticks_b - b0, 3);
    a0 = ticks_a;
    pulse_rc(8);
    check("R4 rc ignored while external", ticks_a - a0, 0);
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, d); check("R3 unkeyed write keeps external", d, 1);
    a0 = ticks_a;
    pulse_xt(1);
    check("R3 ticks unchanged after unkeyed write", ticks_a - a0, 1);
  endtask

  task automatic t_internal_div();
    logic [31:0] d;
    int a0, b0;
    wr(8'h00, 32'h16AA_0000);
    rd(8'h00, d); check("R2 keyed select internal", d, 0);
    wr(8'h08, 32'hFFFF_FFE2);
    rd(8'h08, d); check("R6 presc keeps bits 4:0 only", d, 2);
    a0 = ticks_a; b0 = ticks_b;
    pulse_rc(12);
    check("R5 prediv 4 x (P+1)=3", ticks_a - a0, 1);
    check("R5 bypass x (P+1)=3", ticks_b - b0, 4);
    wr(8'h08, 32'h0000_001F);
    rd(8'h08, d); check("R6 presc max", d, 31);
    b0 = ticks_b; a0 = ticks_a;
    pulse_rc(31);
    check("R6 P=31 no tick at 31 edges", ticks_b - b0, 0);
    pulse_rc(1);
    check("R6 P=31 divides by 32", ticks_b - b0, 1);
    check("R6 P=31 prediv inst no tick", ticks_a - a0, 0);
  endtask

  task automatic t_restart();
    int a0;
    wr(8'h08, 32'h0000_0003);
    pulse_rc(10);
    wr(8'h08, 32'h0000_0001);
    a0 = ticks_a;
    pulse_rc(7);
    check("R7 no tick before new period", ticks_a - a0, 0);
    pulse_rc(1);
    check("R7 first tick after P change", ticks_a - a0, 1);
    pulse_rc(6);
    wr(8'h00, 32'h16AA_0001);
    wr(8'h00, 32'h16AA_0000);
    a0 = ticks_a;
    pulse_rc(2);
    check("R7 source change restarts count", ticks_a - a0, 0);
    pulse_rc(6);
    check("R7 tick after full period post switch", ticks_a - a0, 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h04, 32'h16AA_0001);
    wr(8'h0C, 32'h0000_0007);
    rd(8'h04, d); check("R10 unmapped read zero", d, 0);
    rd(8'h00, d); check("R10 ctrl untouched", d, 0);
    rd(8'h08, d); check("R10 presc untouched", d, 1);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(8'h08, 32'h0000_0000);
    pulse_rc(4);
    check("R8 clkout low while gate off", clko_a, 0);
    wr(8'h60, 32'h0000_0001);
    rd(8'h60, d); check("R8 gate readback", d, 1);
    pulse_rc(4);
    check("R8 clkout toggles high", clko_a, 1);
    pulse_rc(4);
    check("R8 clkout toggles low", clko_a, 0);
    pulse_rc(4);
    check("R8 clkout high again", clko_a, 1);
    wr(8'h60, 32'h0000_0000);
    check("R8 clkout low after gate off", clko_a, 0);
    check("R9 tick single cycle", max_run, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_nokey_internal();
    t_external();
    t_internal_div();
    t_restart();
    t_unmapped();
    t_gate();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule